// File: doc/BRIEF.md
# Cellular-Automaton Substitution Round Function

This block is the mixing function applied to one 64-bit half of a two-half (Feistel) block cipher in each round. It takes a 64-bit half-block and a 64-bit round subkey. It rotates the half-block left by nine positions and cuts the rotated word into eight bytes. Each byte passes through its own small substitution stage. That stage is one step of a second-order, reversible, one-dimensional cellular automaton that uses elementary rule 30. The byte is the current generation, and a fixed preload constant serves as the previous generation. The eight substituted bytes are joined again and XORed with the subkey.

No lookup table is stored: every substitution bit is a three-input rule-30 term XORed with one preload bit. By default the result is registered, so that the block fits a round loop clocked at high speed. Swapping the halves, counting rounds and generating subkeys are left to the surrounding cipher datapath.

Top module: `ca_round_fn`

## Requirements
- R1: Before substitution the half-block is rotated left by 9 bits, so bit k of the rotated word equals bit (k-9) mod 64 of `half_i`.
- R2: Byte j of the rotated word (bits 8j+7..8j, j = 0..7) is substituted on its own, and its output occupies bits 8j+7..8j of the result.
- R3: Within a byte c, output bit i equals c[(i+1) mod 8] XOR (c[i] OR c[(i-1) mod 8]) XOR p[i]. The neighbours wrap around inside the byte: bit 7 uses bit 0 as its upper neighbour, and bit 0 uses bit 7 as its lower neighbour.
- R4: The preload constant p is the parameter `PRELOAD` (default 8'hA5), and all eight bytes share it. With a zero half-block and a zero subkey the result is that constant repeated eight times.
- R5: The joined substitution output is XORed bitwise with `subkey_i`. For a fixed half-block, changing the subkey changes the result by exactly the XOR of the two subkeys.
- R6: With `REG_OUT`=1 (the default), `result_o` shows the function of the inputs sampled at the previous rising clock edge. It does not change between edges, and it holds its value when the inputs are held.
- R7: While `rst_ni` is low, `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_i | input | 64 | Half-block fed to the round function |
| subkey_i | input | 64 | Round subkey |
| result_o | output | 64 | Round function output |

## Verification
The clocked properties assume that the registered variant is selected. They also assume that each input is stable for a whole clock period, so that the value sampled at one edge is the value the register captured. They relate each result to the inputs sampled one or two edges earlier, and they count the edges since reset so that no window reaches back into reset. The bench drives every input on the falling edge and samples on the following falling edge, which keeps within those assumptions. It deliberately holds inputs for several cycles and also changes only the subkey, so that the hold and key-linearity properties are exercised.

// File: rtl/ca_round_pkg.sv
package ca_round_pkg;
  localparam int unsigned HALF_W  = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BOXES = HALF_W / BYTE_W;
  localparam int unsigned ROT_AMT = 9;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [BYTE_W-1:0] cell_row_t;
endpackage

// File: rtl/ca_rotl.sv
module ca_rotl #(
  parameter int unsigned W   = 64,
  parameter int unsigned AMT = 9
) (
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  localparam int unsigned SH = AMT % W;

  generate
    if (SH == 0) begin : g_none
      assign dout_o = din_i;
    end else begin : g_rot
      assign dout_o = {din_i[W-SH-1:0], din_i[W-1:W-SH]};
    end
  endgenerate
endmodule

// File: rtl/ca_sbox.sv
module ca_sbox #(
  parameter int unsigned            W       = 8,
  parameter logic [W-1:0]           PRELOAD = 8'hA5
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  // Second-order step: rule-30 on the current row, XOR the preloaded previous row
  for (genvar i = 0; i < W; i++) begin : g_cell
    localparam int unsigned UP = (i + 1) % W;
    localparam int unsigned DN = (i + W - 1) % W;
    assign nxt_o[i] = cur_i[UP] ^ (cur_i[i] | cur_i[DN]) ^ PRELOAD[i];
  end
endmodule

// File: rtl/ca_sbox_bank.sv
module ca_sbox_bank
  import ca_round_pkg::*;
#(
  parameter cell_row_t PRELOAD = 8'hA5
) (
  input  half_t din_i,
  output half_t dout_o
);
  for (genvar j = 0; j < N_BOXES; j++) begin : g_box
    ca_sbox #(
      .W       (BYTE_W),
      .PRELOAD (PRELOAD)
    ) u_sbox (
      .cur_i (din_i[j*BYTE_W +: BYTE_W]),
      .nxt_o (dout_o[j*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/ca_round_fn.sv
module ca_round_fn
  import ca_round_pkg::*;
#(
  parameter cell_row_t PRELOAD = 8'hA5,
  parameter bit        REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_i,
  input  logic [HALF_W-1:0] subkey_i,
  output logic [HALF_W-1:0] result_o
);
  half_t rot_w;
  half_t sub_w;
  half_t mix_w;

  ca_rotl #(
    .W   (HALF_W),
    .AMT (ROT_AMT)
  ) u_rotl (
    .din_i  (half_i),
    .dout_o (rot_w)
  );

  ca_sbox_bank #(
    .PRELOAD (PRELOAD)
  ) u_bank (
    .din_i  (rot_w),
    .dout_o (sub_w)
  );

  assign mix_w = sub_w ^ subkey_i;

  generate
    if (REG_OUT) begin : g_reg
      half_t res_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= mix_w;
      end
      assign result_o = res_q;
    end else begin : g_comb
      // Reset still forces zero on the output
      assign result_o = rst_ni ? mix_w : '0;
    end
  endgenerate
endmodule

// File: rtl/ca_round_fn_chk.sv
module ca_round_fn_chk
  import ca_round_pkg::*;
#(
  parameter cell_row_t PRELOAD = 8'hA5,
  parameter bit        REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HALF_W-1:0] half_i,
  input logic [HALF_W-1:0] subkey_i,
  input logic [HALF_W-1:0] result_o
);
  logic [1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (result_o == '0); // R7
  end

  generate
    if (REG_OUT) begin : g_reg_props
      AST_ZERO_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edges_q >= 2'd1 && $past(half_i) == '0)
        |-> ((result_o ^ $past(subkey_i)) == {N_BOXES{PRELOAD}})); // R4

      AST_KEY_LINEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edges_q >= 2'd2 && $past(half_i) == $past(half_i, 2))
        |-> ((result_o ^ $past(subkey_i)) == ($past(result_o) ^ $past(subkey_i, 2)))); // R5

      AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edges_q >= 2'd2 && $past(half_i) == $past(half_i, 2)
         && $past(subkey_i) == $past(subkey_i, 2))
        |-> (result_o == $past(result_o))); // R6
    end
  endgenerate
endmodule

bind ca_round_fn ca_round_fn_chk #(
  .PRELOAD (PRELOAD),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .half_i   (half_i),
  .subkey_i (subkey_i),
  .result_o (result_o)
);

// File: tb/ca_round_fn_tb.sv
`timescale 1ns/1ps
module ca_round_fn_tb;
  logic        clk;
  logic        rst_n;
  logic [63:0] half;
  logic [63:0] key;
  logic [63:0] res;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ca_round_fn u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .half_i   (half),
    .subkey_i (key),
    .result_o (res)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Behavioural model: bit-by-bit with integer index arithmetic
  function automatic logic [63:0] model(input logic [63:0] h, input logic [63:0] k);
    logic [63:0] r;
    logic [63:0] o;
    logic [7:0]  pre;
    pre = 8'hA5;
    for (int b = 0; b < 64; b++) r[b] = h[(b + 55) % 64];
    for (int b = 0; b < 64; b++) begin
      int base;
      int pos;
      base = (b / 8) * 8;
      pos  = b % 8;
      o[b] = r[base + (pos + 1) % 8] ^ (r[b] | r[base + (pos + 7) % 8]) ^ pre[pos] ^ k[b];
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] h, input logic [63:0] k, input string req);
    @(negedge clk);
    half = h;
    key  = k;
    #1;
    // R6: no change before the capturing edge (previous result still visible)
    @(negedge clk);
    check(req, res, model(h, k));
  endtask

  initial begin
    logic [63:0] r_a;
    logic [63:0] r_b;
    logic [63:0] prev;
    rst_n = 0;
    half  = 64'hFFFF_0000_1234_5678;
    key   = 64'hDEAD_BEEF_0000_FFFF;
    repeat (3) @(negedge clk);
    check("R7 reset", res, 64'h0);
    @(negedge clk);
    rst_n = 1;

    // R4: zero in, zero key -> preload repeated
    apply(64'h0, 64'h0, "R4 zero input");
    check("R4 preload pattern", res, {8{8'hA5}});

    // R3: wrap at bit 7; half bit 62 lands on rotated bit 7 (R1)
    apply(64'h4000_0000_0000_0000, 64'h0, "R3 wrap");
    check("R3 wrap byte0", res, 64'hA5A5_A5A5_A5A5_A564);

    // R1: half bit 55 lands on rotated bit 0; byte0 = 01 -> 83^A5 = 26
    apply(64'h0080_0000_0000_0000, 64'h0, "R1 rotate");
    check("R1 rotate byte0", res, 64'hA5A5_A5A5_A5A5_A526);

    // R2: walking single bits through every byte
    for (int b = 0; b < 64; b += 5) apply(64'h1 << b, 64'h0, "R2 walk");

    // R5: key linearity
    apply(64'h0123_4567_89AB_CDEF, 64'h0, "R5 key0");
    r_a = res;
    apply(64'h0123_4567_89AB_CDEF, 64'hF0F0_0F0F_3C3C_C3C3, "R5 key1");
    r_b = res;
    check("R5 delta", r_a ^ r_b, 64'hF0F0_0F0F_3C3C_C3C3);

    // R6: hold inputs, output stays; change inputs, old value until edge
    prev = res;
    repeat (3) begin
      @(negedge clk);
      check("R6 hold", res, prev);
    end
    @(posedge clk);
    #1;
    half = 64'hAAAA_5555_AAAA_5555;
    key  = 64'h1;
    #1;
    check("R6 no early change", res, prev);
    @(negedge clk);
    @(negedge clk);
    check("R6 registered", res, model(64'hAAAA_5555_AAAA_5555, 64'h1));

    // Random patterns
    for (int n = 0; n < 200; n++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, "R2 random");

    // R7: async reset clears
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R7 async clear", res, 64'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule